// File: doc/BRIEF.md
# Bus-Inactivity Watchdog and Fixed-Rate Timer

This block is a 10-bit timer that advances once per machine cycle. The machine-cycle tick, one per twelve oscillator periods, is supplied from outside the block. The same counter has two uses, chosen by a mode input.

In watchdog mode it guards a two-wire serial bus. While a transfer is in progress, every bus-activity strobe (an edge on the clock or data line) restarts the count. If 1024 machine cycles pass with no activity, the count wraps and an interrupt is raised, so software can recover the hung bus and repeat the transfer. While no transfer is in progress, the count is held at zero.

In fixed-rate mode the bus inputs are ignored, and the counter gives a periodic interrupt every 1024 machine cycles. The interrupt flag stays set until it is acknowledged, and the counter keeps running meanwhile. Dropping the enable clears both the count and the flag.

Top module: `bus_idle_timer`

## Requirements
- R1: After reset, irq_o is 0 and the count is 0. A full 1024 ticks are needed before the first interrupt.
- R2: With en_i=1 in fixed-rate mode (wdog_mode_i=0), irq_o goes to 1 on the clock edge of the 1024th tick after the count was last zero, and not before.
- R3: The counter keeps running through the wrap and after it. Each later wrap falls exactly 1024 ticks after the previous one.
- R4: Once set, irq_o stays 1 until a cycle with irq_ack_i=1 and en_i=1. After that cycle it reads 0.
- R5: When a wrap and irq_ack_i=1 fall in the same cycle, the set wins and irq_o reads 1.
- R6: Only cycles with tick_i=1 advance the count. Cycles with tick_i=0 leave it unchanged.
- R7: In watchdog mode (wdog_mode_i=1) with xfer_busy_i=1, a cycle with bus_act_i=1 clears the count to 0, whether or not tick_i is high in that cycle. The interrupt follows only after 1024 further ticks with no activity.
- R8: In watchdog mode with xfer_busy_i=0, the count is held at 0 and no interrupt is raised, however many ticks occur.
- R9: A cycle with en_i=0 clears the count to 0 and irq_o to 0. Ticks while disabled do not count.
- R10: In fixed-rate mode, bus_act_i and xfer_busy_i have no effect on counting or on the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle machine-cycle strobe |
| bus_act_i | input | 1 | Bus clock or data edge seen this cycle |
| xfer_busy_i | input | 1 | Serial transfer in progress |
| wdog_mode_i | input | 1 | 1 = bus watchdog, 0 = fixed-rate timer |
| en_i | input | 1 | Timer enable; 0 clears count and flag |
| irq_ack_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions check every cycle that the flag sets on a wrap, holds until acknowledged, and clears on acknowledge or disable. They also check that a clear or a disable zeroes the count, that non-tick cycles leave the count unchanged, and that fixed-rate ticks increment it regardless of bus inputs.

Only the bench scenarios can show the exact 1024-tick distances:
- to the first interrupt after reset, enable, or bus activity;
- between periodic interrupts after an acknowledge mid-period;
- when the tick is sparse.

The bench also shows that no interrupt appears over a long idle period in watchdog mode.

// File: rtl/bidl_pkg.sv
package bidl_pkg;
  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_WDOG  = 1'b1
  } bidl_mode_e;
endpackage

// File: rtl/bidl_ctrl.sv
module bidl_ctrl
  import bidl_pkg::*;
(
  input  logic en_i,
  input  logic tick_i,
  input  logic bus_act_i,
  input  logic xfer_busy_i,
  input  logic wdog_mode_i,
  output logic clr_o,
  output logic adv_o
);
  bidl_mode_e mode;
  logic       wd_hold;

  assign mode = bidl_mode_e'(wdog_mode_i);

  // watchdog: idle bus holds at zero, any edge restarts
  always_comb begin
    wd_hold = 1'b0;
    if (mode == MODE_WDOG) wd_hold = !xfer_busy_i || bus_act_i;
  end

  assign clr_o = !en_i || wd_hold;
  assign adv_o = en_i && tick_i && !clr_o;
endmodule

// File: rtl/bidl_cnt.sv
module bidl_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = adv_i && (cnt_q == CNT_MAX);

  a_r7_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bidl_irq.sv
module bidl_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // set beats acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (!en_i)  irq_q <= 1'b0;
    else if (wrap_i) irq_q <= 1'b1;
    else if (ack_i)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r2_set_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> irq_q);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && irq_q && !ack_i) |=> irq_q);

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ack_i && !wrap_i) |=> !irq_q);

  a_r9_disable_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_q);
endmodule

// File: rtl/bus_idle_timer.sv
module bus_idle_timer #(
  parameter int CNT_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bus_act_i,
  input  logic xfer_busy_i,
  input  logic wdog_mode_i,
  input  logic en_i,
  input  logic irq_ack_i,
  output logic irq_o
);
  logic             clr;
  logic             adv;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  bidl_ctrl u_ctrl (
    .en_i       (en_i),
    .tick_i     (tick_i),
    .bus_act_i  (bus_act_i),
    .xfer_busy_i(xfer_busy_i),
    .wdog_mode_i(wdog_mode_i),
    .clr_o      (clr),
    .adv_o      (adv)
  );

  bidl_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .adv_i (adv),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  bidl_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .wrap_i(wrap),
    .ack_i (irq_ack_i),
    .irq_o (irq_o)
  );

  a_r8_idle_bus_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wdog_mode_i && !xfer_busy_i) |=> (cnt == '0 && !$rose(irq_o)));

  a_r9_disable_clears_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt == '0);

  a_r10_fixed_ignores_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wdog_mode_i && tick_i) |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: tb/bus_idle_timer_tb.sv
`timescale 1ns/1ps
module bus_idle_timer_tb;
  localparam int CNT_W  = 10;
  localparam int PERIOD = 1 << CNT_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, bus_act_i = 1'b0, xfer_busy_i = 1'b0;
  logic wdog_mode_i = 1'b0, en_i = 1'b0, irq_ack_i = 1'b0;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_idle_timer #(.CNT_W(CNT_W)) u_dut (
    .clk_i, .rst_ni, .tick_i, .bus_act_i, .xfer_busy_i,
    .wdog_mode_i, .en_i, .irq_ack_i, .irq_o
  );

  // one clock with the given tick, then sample 1 ns after the edge
  task automatic cyc(input logic t);
    tick_i = t;
    @(posedge clk_i);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected %b", req, irq_o, exp);
    end
  endtask

  task automatic restart;
    en_i = 1'b0;
    cyc(1'b1);
    en_i = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(1'b0, "R1 reset flag");
    rst_ni = 1'b1;
    cyc(1'b0);

    // R1/R2: fixed-rate, first wrap from reset
    en_i = 1'b1;
    ticks(PERIOD - 1);
    chk(1'b0, "R1 R2 before 1024th tick");
    cyc(1'b1);
    chk(1'b1, "R2 on 1024th tick");

    // R4: sticky without ack while counting
    ticks(10);
    chk(1'b1, "R4 flag held");
    irq_ack_i = 1'b1;
    cyc(1'b1);
    irq_ack_i = 1'b0;
    chk(1'b0, "R4 ack clears");
    // R3: count went to 11 through all of this; wrap after 1013 more
    ticks(PERIOD - 11 - 1);
    chk(1'b0, "R3 before next wrap");
    cyc(1'b1);
    chk(1'b1, "R3 periodic wrap");

    // R5: ack held continuously across the next wrap
    irq_ack_i = 1'b1;
    ticks(PERIOD - 1);
    chk(1'b0, "R5 ack cleared flag");
    cyc(1'b1);
    chk(1'b1, "R5 set beats ack");
    irq_ack_i = 1'b0;

    // R9: disable clears flag and count
    ticks(500);
    en_i = 1'b0;
    cyc(1'b1);
    chk(1'b0, "R9 disable clears flag");
    ticks(50);
    chk(1'b0, "R9 ticks while disabled");
    en_i = 1'b1;
    ticks(PERIOD - 1);
    chk(1'b0, "R9 count restarted from zero");
    cyc(1'b1);
    chk(1'b1, "R9 full period after re-enable");

    // R6: tick only every third cycle
    restart();
    for (int i = 0; i < 3 * (PERIOD - 1); i++) cyc(i % 3 == 2);
    cyc(1'b0);
    cyc(1'b0);
    chk(1'b0, "R6 1023 sparse ticks");
    cyc(1'b1);
    chk(1'b1, "R6 1024th sparse tick");

    // R8: watchdog mode, no transfer
    wdog_mode_i = 1'b1;
    xfer_busy_i = 1'b0;
    restart();
    ticks(2 * PERIOD + 7);
    chk(1'b0, "R8 idle bus no irq");
    xfer_busy_i = 1'b1;
    ticks(PERIOD - 1);
    chk(1'b0, "R8 count was held at zero");
    cyc(1'b1);
    chk(1'b1, "R7 timeout during transfer");

    // R7: bus activity restarts the count
    restart();
    ticks(700);
    bus_act_i = 1'b1;
    cyc(1'b1);
    bus_act_i = 1'b0;
    ticks(PERIOD - 1);
    chk(1'b0, "R7 activity restarted count");
    cyc(1'b1);
    chk(1'b1, "R7 timeout after activity");
    restart();
    for (int i = 0; i < 5 * PERIOD; i++) begin
      bus_act_i = (i % 300 == 299);
      cyc(1'b1);
    end
    bus_act_i = 1'b0;
    chk(1'b0, "R7 frequent activity no irq");

    // R10: fixed mode ignores bus inputs
    wdog_mode_i = 1'b0;
    restart();
    for (int i = 0; i < PERIOD - 1; i++) begin
      bus_act_i   = (i % 5 == 0);
      xfer_busy_i = (i % 7 < 3);
      cyc(1'b1);
    end
    chk(1'b0, "R10 before wrap with bus noise");
    bus_act_i = 1'b1;
    cyc(1'b1);
    bus_act_i = 1'b0;
    chk(1'b1, "R10 wrap despite activity");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule